// File: doc/BRIEF.md
# Local Interrupt Source Dispatcher

This block sits between six on-chip interrupt sources and the interrupt request tracker. The sources are the timer, the thermal monitor, the performance counter, two local interrupt lines (line 0 and line 1) and the error reporter. Each source owns a 32-bit vector table entry that holds the vector number to raise, a delivery mode and a mask bit. Software reads and writes these entries over a simple register bus with a write strobe and a combinational read port.

When a source fires, the block remembers it in a pending bit. Each cycle, the lowest-numbered pending source is served and its pending bit is cleared. If the entry is masked, nothing comes out. If the delivery mode is fixed, the block issues a one-cycle vector request carrying the entry's vector. Any other mode produces a one-cycle unhandled-mode error pulse and no request. The timer and error sources are always treated as fixed, whatever their mode field holds. Only fixed delivery reaches the tracker. The special modes (system management, non-maskable, init and external) are flagged but not delivered.

Top module: `irq_source_dispatch`

## Requirements
- R1: After reset every vector table entry reads 0x00010000, so all six sources start masked, and no request or error pulse is produced.
- R2: The entries sit at byte offsets 0x320 (timer, source 0), 0x330 (thermal, 1), 0x340 (performance counter, 2), 0x350 (line 0, 3), 0x360 (line 1, 4) and 0x370 (error, 5). A write stores all 32 bits, and a read returns them. Every other offset, including offsets whose low two bits are non-zero, reads zero and ignores writes.
- R3: Within an entry, bits 7:0 hold the vector, bits 10:8 hold the delivery mode and bit 16 holds the mask. All other bits have no effect on dispatch.
- R4: A served source whose mask bit is 1 produces neither a request nor an error pulse.
- R5: A served, unmasked source in fixed mode (code 0) raises `req_valid` for one cycle, with `req_vector` equal to the entry's vector and `req_src` equal to the source number. A fire sampled at clock edge k is served at edge k+1 and is visible after that edge. `req_vector` is zero whenever `req_valid` is low.
- R6: A served, unmasked thermal, performance counter, line 0 or line 1 source with any non-zero mode (2 system management, 4 non-maskable, 5 init, 7 external, or any other value) raises `mode_err` for one cycle with `req_src` set, and does not raise `req_valid`.
- R7: The timer and error sources raise a fixed request whatever their mode field holds.
- R8: Sources pending together are served one per cycle in the order timer, thermal, performance counter, line 0, line 1, error, with the lowest number first. A newly fired lower-numbered source overtakes higher-numbered sources that are still waiting.
- R9: A fire on a source that is already pending and not being served that cycle merges into the existing pending bit, so the source is served only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| src_fire | input | 6 | Per-source fire strobes, bit n = source n |
| req_valid | output | 1 | One-cycle vector request |
| req_vector | output | 8 | Vector of the request |
| req_src | output | 3 | Source served (valid with `req_valid` or `mode_err`) |
| mode_err | output | 1 | One-cycle unhandled-delivery-mode pulse |

## Verification
Directed passes try one source at a time, first with a clean fixed entry and then with a masked entry. Each of the non-fixed modes is tried on line 1, and then on the timer and error sources. Comparing these separates the mask test from the mode test, and separates the two forced-fixed sources from the four that honour their mode. A burst that fires all six sources at once, with a re-fire of a waiting source, distinguishes correct service order and merging from duplicate or dropped service. Long random runs mix writes to mapped and unmapped offsets with overlapping fires, so that register updates land in the same cycle as service.

// File: rtl/irq_source_dispatch_pkg.sv
// Package: shared source numbering, delivery mode codes and reset value
// for the local interrupt source dispatcher.
package irq_source_dispatch_pkg;

    typedef enum logic [2:0] {
        SRC_TIMER = 3'd0,
        SRC_THERM = 3'd1,
        SRC_PERF  = 3'd2,
        SRC_LINE0 = 3'd3,
        SRC_LINE1 = 3'd4,
        SRC_ERROR = 3'd5
    } src_e;

    localparam logic [2:0] MODE_FIXED  = 3'd0;
    localparam logic [2:0] MODE_SMGMT  = 3'd2;
    localparam logic [2:0] MODE_NONMSK = 3'd4;
    localparam logic [2:0] MODE_INIT   = 3'd5;
    localparam logic [2:0] MODE_EXTERN = 3'd7;

    localparam logic [31:0] ENTRY_RESET = 32'h0001_0000;

    // Sources that ignore their mode field: timer (bit 0) and error (bit 5)
    localparam logic [5:0] FIXED_ONLY_DEFAULT = 6'b10_0001;

endpackage

// File: rtl/irq_source_regs.sv
// Vector table entry storage.
// Holds one DATA_W-bit entry per source at BASE_OFF + n*STRIDE (exact byte
// offset match). Presents the vector, mode and mask fields of every entry.
// Assumes one write at a time on the bus; reads are combinational.
module irq_source_regs #(
    parameter int unsigned          NUM_SRC   = 6,
    parameter int unsigned          ADDR_W    = 12,
    parameter int unsigned          DATA_W    = 32,
    parameter int unsigned          VEC_W     = 8,
    parameter int unsigned          MODE_LO   = 8,
    parameter int unsigned          MODE_W    = 3,
    parameter int unsigned          MASK_BIT  = 16,
    parameter int unsigned          BASE_OFF  = 'h320,
    parameter int unsigned          STRIDE    = 'h10,
    parameter logic [DATA_W-1:0]    RESET_VAL = 32'h0001_0000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic [NUM_SRC*VEC_W-1:0]    vec_flat,
    output logic [NUM_SRC*MODE_W-1:0]   mode_flat,
    output logic [NUM_SRC-1:0]          mask_flat
);

    logic [NUM_SRC-1:0]             hit;
    logic [NUM_SRC-1:0][DATA_W-1:0] rd_part;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_entry
        localparam logic [ADDR_W-1:0] OFF = ADDR_W'(BASE_OFF + g * STRIDE);
        logic [DATA_W-1:0] entry_q;

        assign hit[g] = (bus_addr == OFF);

        // Entry register: reset to masked, load on an addressed write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q <= RESET_VAL;
            end else if (bus_wr && hit[g]) begin
                entry_q <= bus_wdata;
            end
        end

        assign rd_part[g]                     = hit[g] ? entry_q : '0;
        assign vec_flat[g*VEC_W +: VEC_W]     = entry_q[VEC_W-1:0];
        assign mode_flat[g*MODE_W +: MODE_W]  = entry_q[MODE_LO +: MODE_W];
        assign mask_flat[g]                   = entry_q[MASK_BIT];
    end

    // Read mux: OR of the (at most one) addressed entry, zero if unmapped
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            bus_rdata = bus_rdata | rd_part[i];
        end
    end

endmodule

// File: rtl/irq_source_pick.sv
// Pending capture and fixed-priority service selection.
// Fire strobes set pending bits; the lowest-numbered pending source is
// granted each cycle and its bit cleared at the same edge. A fire on the
// granted source in that same cycle re-arms it.
module irq_source_pick #(
    parameter int unsigned NUM_SRC = 6,
    parameter int unsigned IDX_W   = $clog2(NUM_SRC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  fire,
    output logic [NUM_SRC-1:0]  pending,
    output logic [NUM_SRC-1:0]  grant,
    output logic [IDX_W-1:0]    grant_idx
);

    logic [NUM_SRC-1:0] pending_q;
    assign pending = pending_q;

    // Lowest-index-first selection among pending sources
    always_comb begin
        logic found;
        found     = 1'b0;
        grant     = '0;
        grant_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pending_q[i] && !found) begin
                grant[i]  = 1'b1;
                grant_idx = IDX_W'(i);
                found     = 1'b1;
            end
        end
    end

    // Pending state: clear the served bit, merge in new fires
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= '0;
        end else begin
            pending_q <= (pending_q & ~grant) | fire;
        end
    end

endmodule

// File: rtl/irq_source_judge.sv
// Mask and delivery mode evaluation for the granted source.
// Produces registered one-cycle request or error pulses. Sources flagged
// in FIXED_ONLY are treated as fixed regardless of their mode field.
module irq_source_judge
    import irq_source_dispatch_pkg::*;
#(
    parameter int unsigned          NUM_SRC    = 6,
    parameter int unsigned          VEC_W      = 8,
    parameter int unsigned          MODE_W     = 3,
    parameter int unsigned          IDX_W      = $clog2(NUM_SRC),
    parameter logic [NUM_SRC-1:0]   FIXED_ONLY = FIXED_ONLY_DEFAULT
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        grant_any,
    input  logic [IDX_W-1:0]            grant_idx,
    input  logic [NUM_SRC*VEC_W-1:0]    vec_flat,
    input  logic [NUM_SRC*MODE_W-1:0]   mode_flat,
    input  logic [NUM_SRC-1:0]          mask_flat,
    output logic                        req_valid,
    output logic [VEC_W-1:0]            req_vector,
    output logic [IDX_W-1:0]            req_src,
    output logic                        mode_err
);

    logic [VEC_W-1:0]  vec_sel;
    logic [MODE_W-1:0] mode_sel;
    logic              mask_sel;
    logic              fixed_sel;
    logic              deliver;
    logic              reject;

    // Field selection for the granted source and delivery decision
    always_comb begin
        vec_sel   = vec_flat[grant_idx*VEC_W +: VEC_W];
        mode_sel  = mode_flat[grant_idx*MODE_W +: MODE_W];
        mask_sel  = mask_flat[grant_idx];
        fixed_sel = FIXED_ONLY[grant_idx] || (mode_sel == MODE_W'(MODE_FIXED));
        deliver   = grant_any && !mask_sel && fixed_sel;
        reject    = grant_any && !mask_sel && !fixed_sel;
    end

    // Output register: one pulse per served source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid  <= 1'b0;
            mode_err   <= 1'b0;
            req_vector <= '0;
            req_src    <= '0;
        end else begin
            req_valid  <= deliver;
            mode_err   <= reject;
            req_vector <= deliver ? vec_sel : '0;
            req_src    <= grant_any ? grant_idx : '0;
        end
    end

endmodule

// File: rtl/irq_source_dispatch.sv
// Local interrupt source dispatcher (top).
// Six sources fire into pending bits; one is served per cycle in fixed
// priority order; its vector table entry decides between a vector request,
// an unhandled-mode error pulse, or nothing (masked). Assumes fire strobes
// are synchronous to clk.
module irq_source_dispatch
    import irq_source_dispatch_pkg::*;
#(
    parameter int unsigned          NUM_SRC    = 6,
    parameter int unsigned          ADDR_W     = 12,
    parameter int unsigned          DATA_W     = 32,
    parameter int unsigned          VEC_W      = 8,
    parameter int unsigned          MODE_LO    = 8,
    parameter int unsigned          MODE_W     = 3,
    parameter int unsigned          MASK_BIT   = 16,
    parameter int unsigned          BASE_OFF   = 'h320,
    parameter int unsigned          STRIDE     = 'h10,
    parameter logic [NUM_SRC-1:0]   FIXED_ONLY = FIXED_ONLY_DEFAULT
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_wr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    input  logic [NUM_SRC-1:0]           src_fire,
    output logic                         req_valid,
    output logic [VEC_W-1:0]             req_vector,
    output logic [$clog2(NUM_SRC)-1:0]   req_src,
    output logic                         mode_err
);

    localparam int unsigned IDX_W = $clog2(NUM_SRC);

    logic [NUM_SRC*VEC_W-1:0]  vec_flat;
    logic [NUM_SRC*MODE_W-1:0] mode_flat;
    logic [NUM_SRC-1:0]        mask_vec;
    logic [NUM_SRC-1:0]        pending;
    logic [NUM_SRC-1:0]        grant;
    logic [IDX_W-1:0]          grant_idx;
    logic                      grant_any;

    assign grant_any = |grant;

    irq_source_regs #(
        .NUM_SRC   (NUM_SRC),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .VEC_W     (VEC_W),
        .MODE_LO   (MODE_LO),
        .MODE_W    (MODE_W),
        .MASK_BIT  (MASK_BIT),
        .BASE_OFF  (BASE_OFF),
        .STRIDE    (STRIDE),
        .RESET_VAL (DATA_W'(ENTRY_RESET))
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .vec_flat  (vec_flat),
        .mode_flat (mode_flat),
        .mask_flat (mask_vec)
    );

    irq_source_pick #(
        .NUM_SRC   (NUM_SRC),
        .IDX_W     (IDX_W)
    ) pick_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (src_fire),
        .pending   (pending),
        .grant     (grant),
        .grant_idx (grant_idx)
    );

    irq_source_judge #(
        .NUM_SRC    (NUM_SRC),
        .VEC_W      (VEC_W),
        .MODE_W     (MODE_W),
        .IDX_W      (IDX_W),
        .FIXED_ONLY (FIXED_ONLY)
    ) judge_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant_any  (grant_any),
        .grant_idx  (grant_idx),
        .vec_flat   (vec_flat),
        .mode_flat  (mode_flat),
        .mask_flat  (mask_vec),
        .req_valid  (req_valid),
        .req_vector (req_vector),
        .req_src    (req_src),
        .mode_err   (mode_err)
    );

endmodule

// File: rtl/irq_source_dispatch_chk.sv
// Checker for the local interrupt source dispatcher, bound to the top.
// Observes pending/grant state, mask fields and the output pulses.
module irq_source_dispatch_chk #(
    parameter int unsigned          NUM_SRC    = 6,
    parameter logic [NUM_SRC-1:0]   FIXED_ONLY = 6'b10_0001
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SRC-1:0]          pending,
    input  logic [NUM_SRC-1:0]          grant,
    input  logic [NUM_SRC-1:0]          mask_vec,
    input  logic                        req_valid,
    input  logic                        mode_err,
    input  logic [$clog2(NUM_SRC)-1:0]  req_src
);

    logic [NUM_SRC-1:0] mask_prev;

    // Mask fields as they stood at the service edge
    always_ff @(posedge clk) begin
        mask_prev <= mask_vec;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!req_valid && !mode_err && pending == '0));

    // R8
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R6
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && mode_err));

    // R4
    masked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid || mode_err) |-> !mask_prev[req_src]);

    // R7
    forced_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> !FIXED_ONLY[req_src]);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_hold
        // R9
        pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pending[g] && !grant[g]) |=> pending[g]);
    end

endmodule

bind irq_source_dispatch irq_source_dispatch_chk #(
    .NUM_SRC    (NUM_SRC),
    .FIXED_ONLY (FIXED_ONLY)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pending   (pending),
    .grant     (grant),
    .mask_vec  (mask_vec),
    .req_valid (req_valid),
    .mode_err  (mode_err),
    .req_src   (req_src)
);

// File: tb/irq_source_dispatch_tb_top.sv
module irq_source_dispatch_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  src_fire = '0;
    logic        req_valid;
    logic [7:0]  req_vector;
    logic [2:0]  req_src;
    logic        mode_err;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    logic [31:0] m_regs [6];
    logic [5:0]  m_pend;
    logic        e_valid, e_err;
    logic [7:0]  e_vec;
    logic [2:0]  e_src;
    logic [31:0] e_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_source_dispatch dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .src_fire   (src_fire),
        .req_valid  (req_valid),
        .req_vector (req_vector),
        .req_src    (req_src),
        .mode_err   (mode_err)
    );

    // Offset to source number per R2, -1 when unmapped
    function automatic int map_off(input logic [11:0] a);
        for (int i = 0; i < 6; i++) begin
            if (a == 12'h320 + 12'(i * 16)) return i;
        end
        return -1;
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        int k;
        k = map_off(a);
        return (k >= 0) ? m_regs[k] : 32'h0;
    endfunction

    function automatic logic [31:0] entry(input logic mask, input logic [2:0] mode, input logic [7:0] vec);
        return {15'h0, mask, 5'h0, mode, vec};
    endfunction

    task automatic report_end();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            n_fails++;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected < %0d)", cyc, WATCHDOG);
            report_end();
        end
    end

    // Drive one cycle of stimulus, advance the model over the next edge,
    // then compare outputs at the following falling edge.
    task automatic step(input logic [5:0] fire, input logic wr, input logic [11:0] addr,
                        input logic [31:0] wdata, input string tag);
        int          gi;
        logic [31:0] r;
        logic        fx;
        string       t;
        logic [50:0] act, exp;
        src_fire  = fire;
        bus_wr    = wr;
        bus_addr  = addr;
        bus_wdata = wdata;
        gi = -1;
        for (int i = 0; i < 6; i++) if (m_pend[i] && gi < 0) gi = i;
        e_valid = 1'b0; e_err = 1'b0; e_vec = '0; e_src = '0;
        r = '0;
        if (gi >= 0) begin
            r  = m_regs[gi];
            fx = (gi == 0) || (gi == 5) || (r[10:8] == 3'd0);
            if (!r[16]) begin
                e_src = 3'(gi);
                if (fx) begin e_valid = 1'b1; e_vec = r[7:0]; end
                else e_err = 1'b1;
            end
            m_pend[gi] = 1'b0;
        end
        m_pend = m_pend | fire;
        if (wr && map_off(addr) >= 0) m_regs[map_off(addr)] = wdata;
        e_rd = model_read(addr);
        t = tag;
        if (t == "") begin
            if (e_err) t = "R6";
            else if (e_valid && (gi == 0 || gi == 5) && r[10:8] != 3'd0) t = "R7";
            else if (e_valid) t = "R5";
            else if (gi >= 0) t = "R4";
            else t = "R2";
        end
        @(negedge clk);
        act = {req_valid, mode_err, (req_valid || mode_err) ? req_src : 3'd0, req_vector, bus_rdata};
        exp = {e_valid, e_err, e_src, e_vec, e_rd};
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: {valid,err,src,vec,rdata} actual %h expected %h", t, act, exp);
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(6'h0, 1'b0, 12'h000, 32'h0, tag);
    endtask

    initial begin
        logic [2:0] modes [4];
        modes[0] = 3'd2; modes[1] = 3'd4; modes[2] = 3'd5; modes[3] = 3'd7;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 6; i++) m_regs[i] = 32'h0001_0000;
        m_pend = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset readback and quiet outputs, even with fires on masked sources
        for (int i = 0; i < 6; i++) step(6'h0, 1'b0, 12'h320 + 12'(i * 16), 32'h0, "R1");
        step(6'h3F, 1'b0, 12'h320, 32'h0, "R1");
        idle(7, "R1");

        // R2: write/read each entry, then unmapped offsets
        for (int i = 0; i < 6; i++) step(6'h0, 1'b1, 12'h320 + 12'(i * 16), 32'hA5C0_0000 | 32'(i), "R2");
        for (int i = 0; i < 6; i++) step(6'h0, 1'b0, 12'h320 + 12'(i * 16), 32'h0, "R2");
        step(6'h0, 1'b1, 12'h380, 32'hFFFF_FFFF, "R2");
        step(6'h0, 1'b1, 12'h324, 32'hFFFF_FFFF, "R2");
        step(6'h0, 1'b1, 12'h321, 32'hFFFF_FFFF, "R2");
        step(6'h0, 1'b0, 12'h380, 32'h0, "R2");
        step(6'h0, 1'b0, 12'h321, 32'h0, "R2");
        step(6'h0, 1'b0, 12'h320, 32'h0, "R2");

        // R3: only vector, mode and mask fields matter
        step(6'h0, 1'b1, 12'h330, 32'hFFFE_F85A, "R3");
        step(6'h02, 1'b0, 12'h330, 32'h0, "R3");
        idle(2, "R3");

        // R5: plain fixed delivery on line 0
        step(6'h0, 1'b1, 12'h350, entry(1'b0, 3'd0, 8'h31), "R5");
        step(6'h08, 1'b0, 12'h350, 32'h0, "R5");
        idle(2, "R5");

        // R4: masked line 0 stays silent
        step(6'h0, 1'b1, 12'h350, entry(1'b1, 3'd0, 8'h33), "R4");
        step(6'h08, 1'b0, 12'h350, 32'h0, "R4");
        idle(2, "R4");

        // R6: each special mode on line 1 flags an error
        foreach (modes[k]) begin
            step(6'h0, 1'b1, 12'h360, entry(1'b0, modes[k], 8'h40), "R6");
            step(6'h10, 1'b0, 12'h360, 32'h0, "R6");
            idle(2, "R6");
        end

        // R7: timer and error ignore their mode
        step(6'h0, 1'b1, 12'h320, entry(1'b0, 3'd4, 8'h20), "R7");
        step(6'h0, 1'b1, 12'h370, entry(1'b0, 3'd7, 8'hFE), "R7");
        step(6'h21, 1'b0, 12'h370, 32'h0, "R7");
        idle(3, "R7");

        // R8: all six at once, served in order; timer re-fire overtakes
        for (int i = 0; i < 6; i++) step(6'h0, 1'b1, 12'h320 + 12'(i * 16), entry(1'b0, 3'd0, 8'h80 + 8'(i)), "R8");
        step(6'h3F, 1'b0, 12'h320, 32'h0, "R8");
        step(6'h00, 1'b0, 12'h320, 32'h0, "R8");
        step(6'h01, 1'b0, 12'h320, 32'h0, "R8");
        idle(7, "R8");

        // R9: re-fire of a waiting source merges
        step(6'h3F, 1'b0, 12'h320, 32'h0, "R9");
        step(6'h30, 1'b0, 12'h320, 32'h0, "R9");
        step(6'h20, 1'b0, 12'h320, 32'h0, "R9");
        idle(7, "R9");

        // Random mix of writes, reads and overlapping fires
        for (int n = 0; n < 2500; n++) begin
            logic [5:0]  f;
            logic        w;
            logic [11:0] a;
            logic [31:0] d;
            logic [2:0]  md;
            f  = ($urandom_range(0, 2) == 0) ? 6'($urandom()) : 6'h0;
            w  = ($urandom_range(0, 3) == 0);
            a  = ($urandom_range(0, 7) == 0) ? 12'h300 + 12'($urandom_range(0, 127))
                                             : 12'h320 + 12'($urandom_range(0, 5) * 16);
            md = ($urandom_range(0, 2) == 0) ? 3'($urandom()) : 3'd0;
            d  = $urandom();
            d[16]   = ($urandom_range(0, 3) == 0);
            d[10:8] = md;
            step(f, w, a, d, "");
        end
        idle(8, "");

        report_end();
    end

endmodule